// File: doc/BRIEF.md
# CAN Message Slot Control Flags

This block holds the control and status flags of a single message slot in a CAN controller's message memory. Software reads and writes the flags through a bit-masked write port and a read-back word. The protocol engine reports three kinds of event to the block: a matching frame has been stored, a remote frame has arrived for the slot, and the slot's frame has been transmitted. Frame timing, arbitration, identifier filtering and payload storage belong to other blocks.

A direction bit selects receive or transmit use. One flag position changes meaning with the direction. In receive use it is a hardware-owned overwrite indicator that software cannot write. In transmit use it is a software-owned inhibit bit. In receive use, the write-over enable and the data-updated flag together decide whether an incoming frame is taken or dropped. The block tells the payload store whether to accept a frame, tells the transmit scheduler whether the slot may be sent, and raises an interrupt request on receptions.

Top module: `can_slot_flags`

## Requirements
- R1: After a synchronous reset, every flag reads 0, and `tx_eligible`, `irq` and `rx_accept` are 0.
- R2: `sw_rdata` bit layout: 0 direction (1 = transmit, 0 = receive), 1 data-updated, 2 overwrite/inhibit, 3 transmit request, 4 external request, 5 write-over enable, 6 receive interrupt enable, 7 interrupt request. A write updates each bit whose `sw_wr_en` bit is 1 with the matching `sw_wdata` bit, and the new value reads back one cycle later. The exceptions are listed in the requirements below.
- R3: While the direction bit is 0, writes to bit 2 have no effect. While it is 1, bit 2 can be written freely.
- R4: `rx_accept` is combinational and equals `evt_store` AND direction = 0 AND (write-over enable = 1 OR data-updated = 0). A store event in transmit use is never accepted. An accepted store sets data-updated in the next cycle, even if software writes it to 0 in the same cycle.
- R5: An accepted store that finds data-updated already at 1 sets bit 2 (overwrite).
- R6: A store event with write-over enable 0 and data-updated 1 is ignored: data-updated, bit 2 and the interrupt request keep their values.
- R7: In receive use, a software write of 0 to data-updated that is not overridden by an accepted store clears bit 2 in the same update.
- R8: In transmit use, `evt_remote` sets both the transmit request and the external request, whatever the inhibit bit holds. In receive use, `evt_remote` has no effect.
- R9: `evt_tx_done` clears the transmit request. If `evt_remote` arrives in the same cycle, the set wins.
- R10: `tx_eligible` is a registered output. In every cycle it equals direction AND transmit request AND NOT bit 2, taken from the flags that `sw_rdata` shows in that cycle.
- R11: An accepted store while the receive interrupt enable is 1 sets the interrupt request, even against a software write of 0 in the same cycle. Otherwise the interrupt request keeps its value until software writes it. `irq` always equals bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr_en | input | 8 | Per-bit write enables for the flag word |
| sw_wdata | input | 8 | Write data for the flag word |
| sw_rdata | output | 8 | Current flag word |
| evt_store | input | 1 | Protocol side: a frame matched this slot and is offered for storage |
| evt_remote | input | 1 | Protocol side: a remote frame was received for this slot |
| evt_tx_done | input | 1 | Protocol side: this slot's frame was transmitted successfully |
| rx_accept | output | 1 | The offered frame is taken into the slot |
| tx_eligible | output | 1 | The slot may be scheduled for transmission |
| irq | output | 1 | Interrupt request flag |

## Verification
The collisions that matter come from a software write and a protocol event that update the same flag in the same cycle. Examples are clearing data-updated while a store is accepted, clearing the interrupt request while a store sets it, and a remote frame that lands together with a transmit completion. The bench provokes these with directed cycles that drive both strobes at once, and with a long random run that uses sparse write masks and event pulses. It judges each cycle against a next-state function that applies the hardware-wins priority written in the requirements.

// File: rtl/can_slot_pkg.sv
package can_slot_pkg;
  localparam int unsigned FLAG_W = 8;
  localparam int unsigned CFG_W  = 3;

  localparam int unsigned B_DIR   = 0;
  localparam int unsigned B_DTUP  = 1;
  localparam int unsigned B_SHARE = 2;
  localparam int unsigned B_TXREQ = 3;
  localparam int unsigned B_EXTRQ = 4;
  localparam int unsigned B_WOVR  = 5;
  localparam int unsigned B_RXIE  = 6;
  localparam int unsigned B_IRQ   = 7;

  typedef enum logic {
    SLOT_RX = 1'b0,
    SLOT_TX = 1'b1
  } slot_dir_e;
endpackage

// File: rtl/slot_cfg_regs.sv
// Plain software-owned configuration bits: direction, write-over, rx irq enable.
module slot_cfg_regs
  import can_slot_pkg::*;
#(
  parameter int unsigned N = CFG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] we,
  input  logic [N-1:0] wd,
  output logic [N-1:0] q,
  output logic [N-1:0] d
);
  logic [N-1:0] q_r;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign d[i] = we[i] ? wd[i] : q_r[i];
    always_ff @(posedge clk) begin
      if (rst) q_r[i] <= 1'b0;
      else     q_r[i] <= d[i];
    end
  end

  assign q = q_r;
endmodule

// File: rtl/slot_rx_flags.sv
// Receive-side flags: data-updated and interrupt request, plus store acceptance.
module slot_rx_flags
  import can_slot_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  slot_dir_e dir,
  input  logic      wover,
  input  logic      rxie,
  input  logic      evt_store,
  input  logic      we_dtup,
  input  logic      wd_dtup,
  input  logic      we_irq,
  input  logic      wd_irq,
  output logic      accept,
  output logic      ovr_set,
  output logic      ovr_clr,
  output logic      dtup_q,
  output logic      dtup_d,
  output logic      irq_q,
  output logic      irq_d
);
  logic in_rx;

  assign in_rx   = (dir == SLOT_RX);
  assign accept  = evt_store & in_rx & (wover | ~dtup_q);
  assign ovr_set = accept & dtup_q;
  assign ovr_clr = in_rx & we_dtup & ~wd_dtup & ~accept;

  always_comb begin
    dtup_d = dtup_q;
    if (accept)       dtup_d = 1'b1;
    else if (we_dtup) dtup_d = wd_dtup;
  end

  always_comb begin
    irq_d = irq_q;
    if (accept && rxie) irq_d = 1'b1;
    else if (we_irq)    irq_d = wd_irq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dtup_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      dtup_q <= dtup_d;
      irq_q  <= irq_d;
    end
  end
endmodule

// File: rtl/slot_tx_flags.sv
// Transmit-side flags: transmit request and external request.
module slot_tx_flags
  import can_slot_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  slot_dir_e dir,
  input  logic      evt_remote,
  input  logic      evt_tx_done,
  input  logic      we_txreq,
  input  logic      wd_txreq,
  input  logic      we_ext,
  input  logic      wd_ext,
  output logic      txreq_q,
  output logic      txreq_d,
  output logic      ext_q,
  output logic      ext_d
);
  logic rmt_hit;

  assign rmt_hit = evt_remote & (dir == SLOT_TX);

  always_comb begin
    txreq_d = txreq_q;
    if (rmt_hit)          txreq_d = 1'b1;
    else if (evt_tx_done) txreq_d = 1'b0;
    else if (we_txreq)    txreq_d = wd_txreq;
  end

  always_comb begin
    ext_d = ext_q;
    if (rmt_hit)     ext_d = 1'b1;
    else if (we_ext) ext_d = wd_ext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txreq_q <= 1'b0;
      ext_q   <= 1'b0;
    end else begin
      txreq_q <= txreq_d;
      ext_q   <= ext_d;
    end
  end
endmodule

// File: rtl/slot_shared_bit.sv
// One storage bit: overwrite indicator in receive use, inhibit in transmit use.
module slot_shared_bit
  import can_slot_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  slot_dir_e dir,
  input  logic      we,
  input  logic      wd,
  input  logic      ovr_set,
  input  logic      ovr_clr,
  output logic      q,
  output logic      d
);
  always_comb begin
    d = q;
    if (dir == SLOT_RX) begin
      if (ovr_set)      d = 1'b1;
      else if (ovr_clr) d = 1'b0;
    end else if (we) begin
      d = wd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end
endmodule

// File: rtl/can_slot_flags.sv
module can_slot_flags
  import can_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] sw_wr_en,
  input  logic [FLAG_W-1:0] sw_wdata,
  output logic [FLAG_W-1:0] sw_rdata,
  input  logic              evt_store,
  input  logic              evt_remote,
  input  logic              evt_tx_done,
  output logic              rx_accept,
  output logic              tx_eligible,
  output logic              irq
);
  logic [CFG_W-1:0] cfg_we, cfg_wd, cfg_q, cfg_d;
  slot_dir_e dir;
  logic ovr_set, ovr_clr;
  logic dtup_q, dtup_d, irq_q, irq_d;
  logic txreq_q, txreq_d, ext_q, ext_d;
  logic sh_q, sh_d;
  logic elig_q;

  assign cfg_we = {sw_wr_en[B_RXIE], sw_wr_en[B_WOVR], sw_wr_en[B_DIR]};
  assign cfg_wd = {sw_wdata[B_RXIE], sw_wdata[B_WOVR], sw_wdata[B_DIR]};

  slot_cfg_regs #(.N(CFG_W)) u_cfg (
    .clk (clk), .rst (rst), .we (cfg_we), .wd (cfg_wd), .q (cfg_q), .d (cfg_d)
  );

  assign dir = slot_dir_e'(cfg_q[0]);

  slot_rx_flags u_rx (
    .clk       (clk),
    .rst       (rst),
    .dir       (dir),
    .wover     (cfg_q[1]),
    .rxie      (cfg_q[2]),
    .evt_store (evt_store),
    .we_dtup   (sw_wr_en[B_DTUP]),
    .wd_dtup   (sw_wdata[B_DTUP]),
    .we_irq    (sw_wr_en[B_IRQ]),
    .wd_irq    (sw_wdata[B_IRQ]),
    .accept    (rx_accept),
    .ovr_set   (ovr_set),
    .ovr_clr   (ovr_clr),
    .dtup_q    (dtup_q),
    .dtup_d    (dtup_d),
    .irq_q     (irq_q),
    .irq_d     (irq_d)
  );

  slot_tx_flags u_tx (
    .clk         (clk),
    .rst         (rst),
    .dir         (dir),
    .evt_remote  (evt_remote),
    .evt_tx_done (evt_tx_done),
    .we_txreq    (sw_wr_en[B_TXREQ]),
    .wd_txreq    (sw_wdata[B_TXREQ]),
    .we_ext      (sw_wr_en[B_EXTRQ]),
    .wd_ext      (sw_wdata[B_EXTRQ]),
    .txreq_q     (txreq_q),
    .txreq_d     (txreq_d),
    .ext_q       (ext_q),
    .ext_d       (ext_d)
  );

  slot_shared_bit u_sh (
    .clk     (clk),
    .rst     (rst),
    .dir     (dir),
    .we      (sw_wr_en[B_SHARE]),
    .wd      (sw_wdata[B_SHARE]),
    .ovr_set (ovr_set),
    .ovr_clr (ovr_clr),
    .q       (sh_q),
    .d       (sh_d)
  );

  // Eligibility is registered from next-state values so it lines up with the flags.
  always_ff @(posedge clk) begin
    if (rst) elig_q <= 1'b0;
    else     elig_q <= cfg_d[0] & txreq_d & ~sh_d;
  end

  logic [FLAG_W-1:0] rd;
  always_comb begin
    rd          = '0;
    rd[B_DIR]   = cfg_q[0];
    rd[B_DTUP]  = dtup_q;
    rd[B_SHARE] = sh_q;
    rd[B_TXREQ] = txreq_q;
    rd[B_EXTRQ] = ext_q;
    rd[B_WOVR]  = cfg_q[1];
    rd[B_RXIE]  = cfg_q[2];
    rd[B_IRQ]   = irq_q;
  end

  assign sw_rdata    = rd;
  assign tx_eligible = elig_q;
  assign irq         = irq_q;
endmodule

// File: rtl/can_slot_flags_chk.sv
module can_slot_flags_chk
  import can_slot_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [FLAG_W-1:0] sw_wr_en,
  input logic [FLAG_W-1:0] sw_wdata,
  input logic [FLAG_W-1:0] sw_rdata,
  input logic              evt_store,
  input logic              evt_remote,
  input logic              evt_tx_done,
  input logic              rx_accept,
  input logic              tx_eligible,
  input logic              irq
);
  // R3
  rx_share_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (!sw_rdata[B_DIR] && sw_wr_en[B_SHARE] && !evt_store && !sw_wr_en[B_DTUP])
    |=> $stable(sw_rdata[B_SHARE]));

  // R4
  store_sets_dtup_chk: assert property (@(posedge clk) disable iff (rst)
    rx_accept |=> sw_rdata[B_DTUP]);

  // R5
  overwrite_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_accept && sw_rdata[B_DTUP]) |=> sw_rdata[B_SHARE]);

  // R6
  ignored_store_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_store && !sw_rdata[B_DIR] && !sw_rdata[B_WOVR] && sw_rdata[B_DTUP]
     && !sw_wr_en[B_DTUP] && !sw_wr_en[B_IRQ])
    |=> ($stable(sw_rdata[B_DTUP]) && $stable(sw_rdata[B_SHARE]) && $stable(irq)));

  // R7
  dtup_clear_ovr_chk: assert property (@(posedge clk) disable iff (rst)
    (!sw_rdata[B_DIR] && sw_wr_en[B_DTUP] && !sw_wdata[B_DTUP] && !rx_accept)
    |=> !sw_rdata[B_SHARE]);

  // R8
  remote_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_remote && sw_rdata[B_DIR]) |=> (sw_rdata[B_TXREQ] && sw_rdata[B_EXTRQ]));

  // R9
  txdone_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_tx_done && !evt_remote) |=> !sw_rdata[B_TXREQ]);

  // R10
  eligible_match_chk: assert property (@(posedge clk) disable iff (rst)
    tx_eligible == (sw_rdata[B_DIR] && sw_rdata[B_TXREQ] && !sw_rdata[B_SHARE]));

  // R11
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_accept && sw_rdata[B_RXIE]) |=> irq);
endmodule

bind can_slot_flags can_slot_flags_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .sw_wr_en    (sw_wr_en),
  .sw_wdata    (sw_wdata),
  .sw_rdata    (sw_rdata),
  .evt_store   (evt_store),
  .evt_remote  (evt_remote),
  .evt_tx_done (evt_tx_done),
  .rx_accept   (rx_accept),
  .tx_eligible (tx_eligible),
  .irq         (irq)
);

// File: tb/tb_can_slot_flags.sv
`timescale 1ns/1ps
module tb_can_slot_flags;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sw_wr_en = '0, sw_wdata = '0, sw_rdata;
  logic       evt_store = 0, evt_remote = 0, evt_tx_done = 0;
  logic       rx_accept, tx_eligible, irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl = '0;

  always #5 clk = ~clk;

  can_slot_flags dut (
    .clk(clk), .rst(rst), .sw_wr_en(sw_wr_en), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .evt_store(evt_store), .evt_remote(evt_remote), .evt_tx_done(evt_tx_done),
    .rx_accept(rx_accept), .tx_eligible(tx_eligible), .irq(irq)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic acc_of(input logic [7:0] s, input logic st);
    return st & ~s[0] & (s[5] | ~s[1]);
  endfunction

  // Next flag word from the requirements (hardware wins over software).
  function automatic logic [7:0] nxt(input logic [7:0] s, input logic [7:0] we,
                                     input logic [7:0] wd, input logic st,
                                     input logic rm, input logic td);
    logic [7:0] n;
    logic a;
    a = acc_of(s, st);
    n = s;
    for (int i = 0; i < 8; i++)
      if (we[i] && !(i == 2 && !s[0])) n[i] = wd[i];
    if (!s[0] && we[1] && !wd[1] && !a) n[2] = 1'b0;
    if (a) begin
      n[1] = 1'b1;
      if (s[1]) n[2] = 1'b1;
      if (s[6]) n[7] = 1'b1;
    end
    if (td) n[3] = 1'b0;
    if (rm && s[0]) begin
      n[3] = 1'b1;
      n[4] = 1'b1;
    end
    return n;
  endfunction

  function automatic string tag_of(input int b);
    case (b)
      1: return "R4";
      2: return "R5";
      3: return "R9";
      4: return "R8";
      7: return "R11";
      default: return "R2";
    endcase
  endfunction

  task automatic step(input logic [7:0] we, input logic [7:0] wd,
                      input logic st, input logic rm, input logic td);
    logic [7:0] e;
    sw_wr_en = we; sw_wdata = wd; evt_store = st; evt_remote = rm; evt_tx_done = td;
    #1;
    chk(rx_accept == acc_of(mdl, st), "R4", rx_accept, acc_of(mdl, st));
    e = nxt(mdl, we, wd, st, rm, td);
    @(posedge clk);
    #1;
    mdl = e;
    sw_wr_en = '0; evt_store = 0; evt_remote = 0; evt_tx_done = 0;
    for (int b = 0; b < 8; b++)
      chk(sw_rdata[b] == mdl[b], tag_of(b), sw_rdata[b], mdl[b]);
    chk(tx_eligible == (mdl[0] & mdl[3] & ~mdl[2]), "R10", tx_eligible,
        mdl[0] & mdl[3] & ~mdl[2]);
    chk(irq == mdl[7], "R11", irq, mdl[7]);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk(sw_rdata == 8'h00, "R1", sw_rdata, 0);
    chk(tx_eligible == 0 && irq == 0 && rx_accept == 0, "R1",
        {tx_eligible, irq, rx_accept}, 0);

    // R3: receive use, write bit 2 ignored
    step(8'h04, 8'h04, 0, 0, 0);
    chk(sw_rdata[2] == 0, "R3", sw_rdata[2], 0);
    // enable rx interrupt, write-over off
    step(8'h60, 8'h40, 0, 0, 0);
    step(8'h00, 8'h00, 1, 0, 0);
    chk(sw_rdata[1] == 1 && irq == 1, "R11", {sw_rdata[1], irq}, 2'b11);
    // R6: ignored store, irq cleared first
    step(8'h80, 8'h00, 0, 0, 0);
    chk(irq == 0, "R11", irq, 0);
    sw_wr_en = '0; evt_store = 1; #1;
    chk(rx_accept == 0, "R6", rx_accept, 0);
    step(8'h00, 8'h00, 1, 0, 0);
    chk(sw_rdata[2] == 0 && irq == 0 && sw_rdata[1] == 1, "R6",
        {sw_rdata[2], irq, sw_rdata[1]}, 3'b001);
    // R5: write-over on, store over dtup
    step(8'h20, 8'h20, 0, 0, 0);
    step(8'h00, 8'h00, 1, 0, 0);
    chk(sw_rdata[2] == 1, "R5", sw_rdata[2], 1);
    // R7: software clears dtup
    step(8'h02, 8'h00, 0, 0, 0);
    chk(sw_rdata[2] == 0 && sw_rdata[1] == 0, "R7", sw_rdata[2:1], 0);
    // R4: store and software clear collide, store wins; irq clear collides too
    step(8'h82, 8'h00, 1, 0, 0);
    chk(sw_rdata[1] == 1 && irq == 1, "R4", {sw_rdata[1], irq}, 2'b11);
    // R8: remote in receive use ignored
    step(8'h00, 8'h00, 0, 1, 0);
    chk(sw_rdata[4:3] == 0, "R8", sw_rdata[4:3], 0);
    // transmit use
    step(8'h01, 8'h01, 0, 0, 0);
    step(8'h04, 8'h04, 0, 0, 0);
    chk(sw_rdata[2] == 1, "R3", sw_rdata[2], 1);
    step(8'h00, 8'h00, 0, 1, 0);
    chk(sw_rdata[4:3] == 2'b11 && tx_eligible == 0, "R8",
        {sw_rdata[4:3], tx_eligible}, 3'b110);
    step(8'h04, 8'h00, 0, 0, 0);
    chk(tx_eligible == 1, "R10", tx_eligible, 1);
    step(8'h00, 8'h00, 0, 0, 1);
    chk(sw_rdata[3] == 0 && tx_eligible == 0, "R9", {sw_rdata[3], tx_eligible}, 0);
    step(8'h00, 8'h00, 0, 1, 1);
    chk(sw_rdata[3] == 1, "R9", sw_rdata[3], 1);
    // R4: store in transmit use never accepted
    step(8'h00, 8'h00, 1, 0, 0);

    // constrained random phase
    for (int k = 0; k < 4000; k++) begin
      logic [7:0] we, wd;
      for (int b = 0; b < 8; b++) we[b] = ($urandom % 5) == 0;
      wd = 8'($urandom);
      step(we, wd, ($urandom % 3) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule